// File: doc/BRIEF.md
# Link-Partner Lane Status Capture

This block holds one 32-bit status word per serial lane. Each word records what the far end of the link advertises in the control-symbol field of its IDLE2 sequences. The advertised items are an implementation bit, a receiver-trained flag, the partner's port width, the partner's lane number and the partner's Tap(-1) emphasis state. A decoder upstream delivers these items already parsed, together with a strobe for an error-free marker and CS field and a strobe for an errored one. The block also takes the lane's `lane_sync` level.

Software reaches the words through a simple register port. A read is registered and returns its data one cycle later, with a valid strobe. Three bits carry side effects. The "seen" bit is sticky and is cleared by writing 1 to it. The "current" bit is driven by a two-state machine per lane. The "changed" bit records any change in the other 31 bits and is cleared by a read.

The per-lane machine has two states:
- `LS_STALE` (the reset state) moves to `LS_CURRENT` on an accepted marker, meaning a good strobe while `lane_sync` is high and no error strobe is present.
- `LS_CURRENT` returns to `LS_STALE` on an error strobe or when `lane_sync` falls. Otherwise it stays in `LS_CURRENT`.

Top module: `far_lane_status`

## Requirements
- R1: Bit 31 (seen) sets whenever a good or errored marker strobe arrives on the lane, whatever the level of `lane_sync`. A write to the lane's address with `reg_wdata[31]=1` clears it. A write with `reg_wdata[31]=0` leaves it unchanged. A new marker in the same cycle as the clearing write wins.
- R2: Bit 30 (current) reads 1 after an accepted marker, that is a good strobe with `lane_sync=1` and no error strobe.
- R3: Bit 30 drops to 0 after an error strobe or while `lane_sync=0`. The captured fields are kept. When the good and error strobes arrive together, the error wins and nothing is captured.
- R4: The captured fields update only on an accepted marker. A good strobe without `lane_sync` captures nothing. The field positions are: bit 28 implementation bit, bit 27 receiver trained, bits 26:24 port width (000=1, 001=2, 010=4, 011=8, 100=16 lanes; 101 to 111 reserved and stored as received), bits 23:20 partner lane number, and bits 19:18 Tap(-1) (00 absent, 01 minimum, 10 maximum, 11 intermediate).
- R5: Bit 29 (changed) sets when any other bit of the word changes value, and clears after a read of that lane.
- R6: If a change occurs in the same cycle as a read of the lane, bit 29 remains set.
- R7: After reset, every bit of every lane's word is 0.
- R8: Lane i is at address 0x214 + 0x20*i. A read returns data on `reg_rdata` with `reg_rd_valid=1` in the cycle after `reg_rd`. Unmapped addresses read 0, and bits 17:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_sync | input | NUM_LANES | Per-lane sync level |
| cs_good | input | NUM_LANES | Error-free marker and CS field received |
| cs_bad | input | NUM_LANES | Errored marker or CS field received |
| cs_impl | input | NUM_LANES | Implementation-defined CS bit |
| cs_trained | input | NUM_LANES | Partner receiver trained |
| cs_width | input | 3*NUM_LANES | Partner port width code |
| cs_lane | input | 4*NUM_LANES | Partner lane number |
| cs_tap | input | 2*NUM_LANES | Partner Tap(-1) state |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data (one cycle after reg_rd) |
| reg_rd_valid | output | 1 | Read data valid |

## Verification
The bench builds the block with its defaults: four lanes, a base address of 0x214, a stride of 0x20 and 12 address bits. With these values every lane address from 0x214 up to 0x274 can be reached, as can an unmapped address between two lanes. Lane 3 is driven as well as lane 0, so both ends of the decode and the read-back OR tree are exercised.

// File: rtl/fls_pkg.sv
package fls_pkg;
    localparam int WORD_W  = 32;
    localparam int WIDTH_W = 3;
    localparam int LNUM_W  = 4;
    localparam int TAP_W   = 2;

    typedef enum logic {
        LS_STALE   = 1'b0,
        LS_CURRENT = 1'b1
    } lane_state_e;

    typedef struct packed {
        logic               impl;
        logic               trained;
        logic [WIDTH_W-1:0] width;
        logic [LNUM_W-1:0]  lnum;
        logic [TAP_W-1:0]   tap;
    } cs_fields_t;
endpackage

// File: rtl/fls_addr_dec.sv
module fls_addr_dec #(
    parameter int NUM_LANES = 4,
    parameter int ADDR_W    = 12,
    parameter int BASE      = 'h214,
    parameter int STRIDE    = 'h20
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LANES-1:0] sel
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE + STRIDE * g);
        assign sel[g] = (addr == LANE_ADDR);
    end
endmodule

// File: rtl/fls_lane_reg.sv
module fls_lane_reg
    import fls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane_sync,
    input  logic              cs_good,
    input  logic              cs_bad,
    input  cs_fields_t        cs_in,
    input  logic              rd_hit,
    input  logic              wr_hit,
    input  logic              wr_seen_clr,
    output logic [WORD_W-1:0] word
);
    lane_state_e state_q, state_d;
    cs_fields_t  fields_q;
    logic        seen_q, chg_q;
    logic        take, rx_any, clr_req, seen_d;
    logic        diff;

    assign take    = cs_good && lane_sync && !cs_bad;
    assign rx_any  = cs_good || cs_bad;
    assign clr_req = wr_hit && wr_seen_clr;
    assign seen_d  = rx_any ? 1'b1 : (clr_req ? 1'b0 : seen_q);

    // next-state logic of the currency machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_STALE:   if (take) state_d = LS_CURRENT;
            LS_CURRENT: if (cs_bad || !lane_sync) state_d = LS_STALE;
            default:    state_d = LS_STALE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_STALE;
        else        state_q <= state_d;
    end

    // difference between the next and present images of the other 31 bits
    always_comb begin
        diff = (seen_d != seen_q) || (state_d != state_q);
        if (take && (cs_in != fields_q)) diff = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
            seen_q   <= 1'b0;
            chg_q    <= 1'b0;
        end else begin
            seen_q <= seen_d;
            if (take) fields_q <= cs_in;
            if (diff)        chg_q <= 1'b1;
            else if (rd_hit) chg_q <= 1'b0;
        end
    end

    // output image
    always_comb begin
        word        = '0;
        word[31]    = seen_q;
        word[30]    = (state_q == LS_CURRENT);
        word[29]    = chg_q;
        word[28:18] = fields_q;
    end

    AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (word[31] && !clr_req) |=> word[31]); // R1
    AST_STALE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_bad || !lane_sync) |=> !word[30]); // R3
    AST_FIELDS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_good && lane_sync && !cs_bad) |=> $stable(word[28:18])); // R4
    AST_CHG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (word[29] && !rd_hit) |=> word[29]); // R5
endmodule

// File: rtl/far_lane_status.sv
module far_lane_status
    import fls_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int ADDR_W    = 12,
    parameter int BASE      = 'h214,
    parameter int STRIDE    = 'h20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES-1:0]        lane_sync,
    input  logic [NUM_LANES-1:0]        cs_good,
    input  logic [NUM_LANES-1:0]        cs_bad,
    input  logic [NUM_LANES-1:0]        cs_impl,
    input  logic [NUM_LANES-1:0]        cs_trained,
    input  logic [WIDTH_W*NUM_LANES-1:0] cs_width,
    input  logic [LNUM_W*NUM_LANES-1:0]  cs_lane,
    input  logic [TAP_W*NUM_LANES-1:0]   cs_tap,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_wr,
    input  logic [WORD_W-1:0]           reg_wdata,
    input  logic                        reg_rd,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic                        reg_rd_valid
);
    logic [NUM_LANES-1:0] sel;
    logic [WORD_W-1:0]    words [NUM_LANES];
    logic [WORD_W-1:0]    acc   [NUM_LANES+1];

    fls_addr_dec #(
        .NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
    ) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    assign acc[0] = '0;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        cs_fields_t fin;
        assign fin.impl    = cs_impl[g];
        assign fin.trained = cs_trained[g];
        assign fin.width   = cs_width[g*WIDTH_W +: WIDTH_W];
        assign fin.lnum    = cs_lane[g*LNUM_W +: LNUM_W];
        assign fin.tap     = cs_tap[g*TAP_W +: TAP_W];

        fls_lane_reg u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .lane_sync   (lane_sync[g]),
            .cs_good     (cs_good[g]),
            .cs_bad      (cs_bad[g]),
            .cs_in       (fin),
            .rd_hit      (reg_rd && sel[g]),
            .wr_hit      (reg_wr && sel[g]),
            .wr_seen_clr (reg_wdata[31]),
            .word        (words[g])
        );

        assign acc[g+1] = acc[g] | (sel[g] ? words[g] : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata    <= '0;
            reg_rd_valid <= 1'b0;
        end else begin
            reg_rd_valid <= reg_rd;
            if (reg_rd) reg_rdata <= acc[NUM_LANES];
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R8
    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rd_valid); // R8
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_valid |-> (reg_rdata[17:0] == '0)); // R8
endmodule

// File: tb/test_far_lane_status.sv
module test_far_lane_status;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0]   lane_sync = '0, cs_good = '0, cs_bad = '0, cs_impl = '0, cs_trained = '0;
    logic [3*N-1:0] cs_width = '0;
    logic [4*N-1:0] cs_lane = '0;
    logic [2*N-1:0] cs_tap = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rd_valid;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    far_lane_status i_far_lane_status (
        .clk(clk), .rst_n(rst_n), .lane_sync(lane_sync), .cs_good(cs_good),
        .cs_bad(cs_bad), .cs_impl(cs_impl), .cs_trained(cs_trained),
        .cs_width(cs_width), .cs_lane(cs_lane), .cs_tap(cs_tap),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rd_valid(reg_rd_valid)
    );

    // lane, sync, good, bad, impl, trained, width[3], lnum[4], tap[2], expected[32]
    localparam logic [47:0] VECS [8] = '{
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'b010, 4'd0, 2'b11, 32'hFA0C_0000},
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'b010, 4'd0, 2'b11, 32'hBA0C_0000},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'b010, 4'd0, 2'b11, 32'hFA0C_0000},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'b010, 4'd0, 2'b11, 32'hDA0C_0000},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 4'd0, 2'b00, 32'hBA0C_0000},
        {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b100, 4'd1, 2'b01, 32'hE414_0000},
        {2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'b011, 4'd7, 2'b10, 32'hA414_0000},
        {2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b001, 4'd5, 2'b11, 32'hA000_0000}
    };
    localparam string VTAG [8] = '{"R2 R4 R5", "R3 R5", "R2 R5", "R5 no change",
                                   "R3 sync loss", "R2 R4 R8", "R3 err wins", "R1 R4 no sync"};

    function automatic logic [11:0] lane_addr(input int l);
        return 12'(32'h214 + 32'h20 * l);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R8 valid", {31'd0, reg_rd_valid}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] wd);
        @(negedge clk);
        reg_addr = a; reg_wdata = wd; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state of every lane
        for (int l = 0; l < N; l++) begin
            do_read(lane_addr(l), d);
            check("R7 reset", d, 32'h0);
        end

        // vector table
        for (int v = 0; v < 8; v++) begin
            logic [47:0] e;
            int l;
            e = VECS[v];
            l = int'(e[47:46]);
            @(negedge clk);
            lane_sync[l]        = e[45];
            cs_good[l]          = e[44];
            cs_bad[l]           = e[43];
            cs_impl[l]          = e[42];
            cs_trained[l]       = e[41];
            cs_width[l*3 +: 3]  = e[40:38];
            cs_lane[l*4 +: 4]   = e[37:34];
            cs_tap[l*2 +: 2]    = e[33:32];
            @(negedge clk);
            cs_good = '0; cs_bad = '0;
            do_read(lane_addr(l), d);
            check(VTAG[v], d, e[31:0]);
        end

        // R5: lane 0 change bit was cleared by the last read
        do_read(lane_addr(0), d);
        check("R5 cleared by read", d, 32'h9A0C_0000);

        // R1: writing 0 to the seen bit has no effect
        do_write(lane_addr(0), 32'h7FFF_FFFF);
        do_read(lane_addr(0), d);
        check("R1 write0 ignored", d, 32'h9A0C_0000);

        // R1: writing 1 clears seen, which marks a change
        do_write(lane_addr(0), 32'h8000_0000);
        do_read(lane_addr(0), d);
        check("R1 w1c", d, 32'h3A0C_0000);

        // R6: a change in the same cycle as a read keeps bit 29
        @(negedge clk);
        lane_sync[2] = 1'b1;
        cs_good[2] = 1'b1;
        reg_addr = lane_addr(2); reg_rd = 1'b1;
        @(negedge clk);
        cs_good = '0; reg_rd = 1'b0;
        check("R6 old data", reg_rdata, 32'h0);
        do_read(lane_addr(2), d);
        check("R6 change kept", d, 32'hE000_0000);
        do_read(lane_addr(2), d);
        check("R5 cleared", d, 32'hC000_0000);

        // R8: an unmapped address reads zero
        do_read(12'h218, d);
        check("R8 unmapped", d, 32'h0);

        // R1: a new marker beats the clearing write in the same cycle
        @(negedge clk);
        cs_bad[3] = 1'b1;
        reg_addr = lane_addr(3); reg_wdata = 32'h8000_0000; reg_wr = 1'b1;
        @(negedge clk);
        cs_bad = '0; reg_wr = 1'b0;
        do_read(lane_addr(3), d);
        check("R1 set wins", d[31:30], 2'b10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule